// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Actions

This block watches a running counter. Software must kick the counter before it reaches the selected period. If a period ends without a kick, the block takes an action set by its control register. The action can be nothing, an interrupt, a single-cycle system-reset pulse, or an interrupt first with a reset on the next expiry. A fuse input forces the reset action whatever the register bits say. A sticky reset-flag, set and cleared by strobes, keeps the reset action on so that a failing system cannot switch it off.

The control register is written through a single-cycle strobe with an 8-bit data bus. It is read back at all times. The reset-enable bit and the period select are protected: to clear the reset enable or to change the period, software must first open a short window by writing the change-enable bit. The block has no streaming data path. All pins are plain control and status signals.

Register bits, where the behaviour depends on the position: bit 7 is the expiry flag (write 1 to clear), bit 6 is the interrupt enable, bit 5 is the MSB of the 4-bit period select, bit 4 is change-enable, bit 3 is reset-enable, and bits 2..0 are the low bits of the period select.

Top module: `wdog_ctl`

## Requirements
- R1: After power-on reset the readback is 0x00, irq_o is 0 and sys_rst_o is 0.
- R2: The action is set by {reset-enable, interrupt-enable} when fuse_on_i is 0: 00 does nothing, 01 gives an interrupt, 10 gives a reset, 11 gives an interrupt then a reset. With the action 00, expiries cause no flag, no interrupt and no reset.
- R3: With period select n, the period is 2^(BASE_LOG+n) ticks for n from 0 to 9. Select values 10 to 15 behave as 9.
- R4: A kick restarts the count from zero. So do every expiry and every accepted change of the period select. The first action comes one period after the restart.
- R5: In interrupt mode an expiry sets bit 7 and causes no reset. irq_o is high exactly while bit 7, bit 6 and gie_i are all 1.
- R6: Bit 7 clears on an irq_ack_i pulse or on a write with bit 7 = 1. A write with bit 7 = 0 leaves it unchanged.
- R7: In interrupt-then-reset mode the first expiry sets bit 7. An acknowledge clears bits 7 and 6, which leaves the block in reset-only mode. An expiry while bit 7 is still set gives a system reset.
- R8: In reset mode an expiry gives a sys_rst_o pulse of exactly one cycle, and bit 7 stays 0.
- R9: With fuse_on_i = 1 the block acts in reset mode even when bits 3 and 6 are 0.
- R10: A write with bit 4 = 1 opens the change window for four cycles, after which bit 4 reads 0. A write that clears bit 3 or changes the period select takes effect only if the window was open before that write. Setting bit 3 and writing bits 6 and 7 need no window.
- R11: rflag_set_i sets the sticky reset-flag and rflag_clr_i clears it. While the flag is set, bit 3 reads 1 and cannot be cleared. After the flag is cleared, bit 3 stays 1 until a windowed write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | Count tick from the prescaler source |
| fuse_on_i | input | 1 | 1 forces reset mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| kick_i | input | 1 | Restart the count |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| rflag_set_i | input | 1 | Sets the sticky reset-flag |
| rflag_clr_i | input | 1 | Clears the sticky reset-flag |
| rd_data_o | output | 8 | Register readback |
| irq_o | output | 1 | Interrupt request |
| sys_rst_o | output | 1 | Single-cycle system-reset pulse |

## Verification
The hardest state to reach is the reset from interrupt-then-reset mode. The bench must let one expiry set the flag, then either acknowledge it or leave it set, and catch the second expiry exactly one period later. A smaller BASE_LOG keeps these periods short. The bench counts cycles from a known restart to each action, so a one-cycle error in the period shows up. The change window is probed with writes that land on the last open cycle and on the first closed cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W   = 4;
  localparam int B_FLAG  = 7;
  localparam int B_IE    = 6;
  localparam int B_SELHI = 5;
  localparam int B_CE    = 4;
  localparam int B_RE    = 3;

  typedef enum logic [1:0] {
    MODE_STOP    = 2'b00,
    MODE_IRQ     = 2'b01,
    MODE_RST     = 2'b10,
    MODE_IRQ_RST = 2'b11
  } wd_mode_e;

  function automatic wd_mode_e mode_of(logic fuse, logic re, logic ie);
    if (fuse) return MODE_RST;
    case ({re, ie})
      2'b01:   return MODE_IRQ;
      2'b10:   return MODE_RST;
      2'b11:   return MODE_IRQ_RST;
      default: return MODE_STOP;
    endcase
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CE_WINDOW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fuse_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic             ack_i,
  input  logic             set_flag_i,
  input  logic             rflag_set_i,
  input  logic             rflag_clr_i,
  output logic             flag_o,
  output logic             ie_o,
  output wd_mode_e         mode_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             sel_chg_o,
  output logic [7:0]       rd_o
);
  localparam int CW = (CE_WINDOW > 1) ? $clog2(CE_WINDOW) : 1;

  logic             ce_q, re_q, ie_q, flag_q, rf_q;
  logic [CW-1:0]    ce_cnt;
  logic [SEL_W-1:0] sel_q, sel_new;
  logic             re_eff;

  assign sel_new   = {wr_data_i[B_SELHI], wr_data_i[2:0]};
  assign sel_chg_o = wr_en_i && ce_q && (sel_new != sel_q);
  assign re_eff    = re_q | rf_q;
  assign mode_o    = mode_of(fuse_i, re_eff, ie_q);

  // change-enable window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      ce_cnt <= '0;
    end else if (wr_en_i) begin
      ce_q   <= wr_data_i[B_CE];
      ce_cnt <= CW'(CE_WINDOW - 1);
    end else if (ce_q) begin
      if (ce_cnt == '0) ce_q <= 1'b0;
      else              ce_cnt <= ce_cnt - 1'b1;
    end
  end

  // sticky reset-flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rf_q <= 1'b0;
    else if (rflag_set_i) rf_q <= 1'b1;
    else if (rflag_clr_i) rf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q   <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (rf_q) re_q <= 1'b1;
      else if (wr_en_i) begin
        if (wr_data_i[B_RE]) re_q <= 1'b1;
        else if (ce_q)       re_q <= 1'b0;
      end
      if (ack_i && mode_o == MODE_IRQ_RST) ie_q <= 1'b0;
      else if (wr_en_i)                    ie_q <= wr_data_i[B_IE];
      if (set_flag_i) flag_q <= 1'b1;
      else if (ack_i || (wr_en_i && wr_data_i[B_FLAG])) flag_q <= 1'b0;
      if (wr_en_i && ce_q) sel_q <= sel_new;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign sel_o  = sel_q;
  assign rd_o   = {flag_q, ie_q, sel_q[3], ce_q, re_eff, sel_q[2:0]};

  AST_SEL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ce_q) |=> $stable(sel_q)); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_flag_i) |=> !flag_q); // R6
  AST_IE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && mode_o == MODE_IRQ_RST) |=> !ie_q); // R7
  AST_RE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_q && wr_en_i) |=> re_q); // R11
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_LOG = 11,
  parameter int MAX_SEL  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam int CNT_W = BASE_LOG + MAX_SEL;
  localparam int SHW   = $clog2(CNT_W + 1) + 1;

  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic [CNT_W:0]   lim_full;
  logic [SEL_W-1:0] eff;
  logic [SHW-1:0]   sh;

  always_comb begin
    eff      = (sel_i > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel_i;
    sh       = SHW'(BASE_LOG) + SHW'(eff);
    lim_full = ((CNT_W + 1)'(1) << sh) - (CNT_W + 1)'(1);
    lim_m1   = lim_full[CNT_W-1:0];
  end

  assign expire_o = run_i && tick_i && !kick_i && !restart_i && (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     cnt_q <= '0;
    else if (!run_i || kick_i || restart_i || expire_o) cnt_q <= '0;
    else if (tick_i)                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     expire_i,
  input  wd_mode_e mode_i,
  input  logic     flag_i,
  output logic     set_flag_o,
  output logic     sys_rst_o
);
  logic fire, sys_rst_q;

  assign set_flag_o = expire_i && (mode_i == MODE_IRQ || (mode_i == MODE_IRQ_RST && !flag_i));
  assign fire       = expire_i && (mode_i == MODE_RST || (mode_i == MODE_IRQ_RST && flag_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sys_rst_q <= 1'b0;
    else         sys_rst_q <= fire;
  end
  assign sys_rst_o = sys_rst_q;

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_q |=> !sys_rst_q); // R8
  AST_IRQ_MODE_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i == MODE_IRQ) |=> !sys_rst_q); // R5
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
#(
  parameter int BASE_LOG  = 11,
  parameter int MAX_SEL   = 9,
  parameter int CE_WINDOW = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fuse_on_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       kick_i,
  input  logic       irq_ack_i,
  input  logic       gie_i,
  input  logic       rflag_set_i,
  input  logic       rflag_clr_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       sys_rst_o
);
  logic             flag, ie, sel_chg, expire, set_flag;
  wd_mode_e         mode;
  logic [SEL_W-1:0] sel;

  wdog_regs #(.CE_WINDOW(CE_WINDOW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .fuse_i(fuse_on_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ack_i(irq_ack_i),
    .set_flag_i(set_flag), .rflag_set_i(rflag_set_i), .rflag_clr_i(rflag_clr_i),
    .flag_o(flag), .ie_o(ie), .mode_o(mode), .sel_o(sel),
    .sel_chg_o(sel_chg), .rd_o(rd_data_o)
  );

  wdog_timer #(.BASE_LOG(BASE_LOG), .MAX_SEL(MAX_SEL)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(mode != MODE_STOP),
    .tick_i(tick_i), .kick_i(kick_i), .restart_i(sel_chg),
    .sel_i(sel), .expire_o(expire)
  );

  wdog_action u_action (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .mode_i(mode),
    .flag_i(flag), .set_flag_o(set_flag), .sys_rst_o(sys_rst_o)
  );

  assign irq_o = flag && ie && gie_i;

  AST_FUSE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_on_i && expire) |=> sys_rst_o); // R9
endmodule

// File: tb/wdog_ctl_tb.sv
module wdog_ctl_tb;
  localparam int BL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, fuse = 1'b0, wr_en = 1'b0, kick = 1'b0, ack = 1'b0;
  logic gie = 1'b0, rf_set = 1'b0, rf_clr = 1'b0;
  logic [7:0] wdata = '0, rd;
  logic irq, srst;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  wdog_ctl #(.BASE_LOG(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fuse_on_i(fuse),
    .wr_en_i(wr_en), .wr_data_i(wdata), .kick_i(kick), .irq_ack_i(ack),
    .gie_i(gie), .rflag_set_i(rf_set), .rflag_clr_i(rf_clr),
    .rd_data_o(rd), .irq_o(irq), .sys_rst_o(srst)
  );

  // write data, expected readback; one write per cycle, ticks held off
  localparam logic [15:0] VEC [0:8] = '{
    16'h0808, 16'h0008, 16'h0908, 16'h1818, 16'h0101,
    16'h4041, 16'h8001, 16'h3819, 16'h2020
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered at a negedge and leave at a negedge
  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wdata = d; @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic pulse_kick(); kick = 1'b1; @(negedge clk); kick = 1'b0; endtask
  task automatic pulse_ack();  ack  = 1'b1; @(negedge clk); ack  = 1'b0; endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic cfg(logic [7:0] d); wr(8'h10 | (d & 8'h48)); wr(d); endtask

  // which: 0 irq, 1 reset, 2 either
  task automatic measure(int which, int max, output int c);
    c = 0;
    while (c < max && !((which != 1 && irq) || (which != 0 && srst))) begin
      @(negedge clk); c++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd", rd, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rst", srst, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][15:8]);
      chk($sformatf("R10 vec%0d", i), rd, VEC[i][7:0]);
    end

    tick = 1'b1;
    // stopped
    cfg(8'h00); pulse_kick(); measure(2, 48, c);
    chk("R2 stopped no action", c, 48);

    // interrupt mode
    wr(8'h40); gie = 1'b1; pulse_kick(); measure(0, 1000, c);
    chk("R5 irq period", c, 16);
    chk("R5 flag rd", rd, 8'hC0);
    pulse_ack();
    chk("R6 ack irq", irq, 0);
    chk("R6 ack rd", rd, 8'h40);

    gie = 1'b0; pulse_kick(); idle(18);
    chk("R5 gie off irq", irq, 0);
    chk("R5 gie off flag", rd, 8'hC0);
    wr(8'h40);
    chk("R6 write0 keeps", rd, 8'hC0);
    wr(8'hC0);
    chk("R6 write1 clears", rd, 8'h40);
    gie = 1'b1;

    // periods
    cfg(8'h43); pulse_kick(); measure(0, 20000, c);
    chk("R3 sel3", c, 128); pulse_ack();
    cfg(8'h61); pulse_kick(); measure(0, 20000, c);
    chk("R3 sel9", c, 8192); pulse_ack();
    cfg(8'h64); pulse_kick(); measure(0, 20000, c);
    chk("R3 sel12 as 9", c, 8192); pulse_ack();

    // restarts
    cfg(8'h40); pulse_kick(); idle(10); pulse_kick(); measure(0, 1000, c);
    chk("R4 kick restart", c, 16); pulse_ack();
    pulse_kick(); idle(10); wr(8'h50); wr(8'h41); measure(0, 1000, c);
    chk("R4 sel change restart", c, 32); pulse_ack();

    // reset mode
    wr(8'h58); wr(8'h08); pulse_kick(); measure(1, 1000, c);
    chk("R8 reset period", c, 16);
    chk("R8 no flag", rd, 8'h08);
    @(negedge clk);
    chk("R8 one cycle", srst, 0);

    // interrupt then reset
    wr(8'h48); pulse_kick(); measure(0, 1000, c);
    chk("R7 first irq", c, 16);
    chk("R7 no reset yet", srst, 0);
    pulse_ack();
    chk("R7 ack drops ie", rd, 8'h08);
    measure(1, 1000, c);
    chk("R7 reset after ack", c, 15);
    wr(8'h48); pulse_kick(); measure(0, 1000, c);
    chk("R7 irq again", c, 16);
    measure(1, 1000, c);
    chk("R7 unserviced reset", c, 16);
    chk("R7 flag held", rd, 8'hC8);
    wr(8'hC8);

    // fuse
    wr(8'h10); wr(8'h00);
    chk("R9 cleared", rd, 8'h00);
    fuse = 1'b1; pulse_kick(); measure(2, 1000, c);
    chk("R9 fuse period", c, 16);
    chk("R9 fuse reset", srst, 1);
    chk("R9 no flag", rd, 8'h00);
    fuse = 1'b0;

    // sticky reset flag
    rf_set = 1'b1; @(negedge clk); rf_set = 1'b0;
    chk("R11 re forced", rd, 8'h08);
    wr(8'h10); wr(8'h00);
    chk("R11 clear blocked", rd, 8'h08);
    rf_clr = 1'b1; @(negedge clk); rf_clr = 1'b0;
    chk("R11 stays after flag clear", rd, 8'h08);
    wr(8'h10); wr(8'h00);
    chk("R11 clear allowed", rd, 8'h00);

    // window edges
    tick = 1'b0;
    wr(8'h18); idle(3); wr(8'h01);
    chk("R10 last open cycle", rd, 8'h01);
    wr(8'h18); idle(4);
    chk("R10 window closed", rd, 8'h09);
    wr(8'h00);
    chk("R10 late write ignored", rd, 8'h09);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule